// File: doc/BRIEF.md
# Per-Lane Write-Validate Data Cache

This block is a small private data cache placed in front of a single execution lane of a wide parallel processor. It absorbs that lane's loads and stores so that the shared on-chip memories see fewer requests. Lines are held write-back: a store changes only the cached copy, and memory receives data only when a line is evicted or when the cache is flushed. No coherence is kept with any other lane. Software must synchronise and flush before data is shared.

A store that misses does not read the line. It claims an entry and marks only the bytes it wrote as valid and dirty. A load is a hit only when every byte it asks for is valid. When some requested bytes are missing, the whole line is read from memory and laid under the bytes already held, so locally written bytes are kept. On eviction or flush, only dirty bytes go back to memory, under a per-byte write mask. A victim with no dirty bytes is dropped silently.

The lane side uses a valid/ready request with a one-cycle registered load response. The memory side carries one request at a time: either a masked full-line write or a line read whose data returns later on a separate valid strobe. A flush pulse writes back every dirty entry, empties the cache and signals completion with a single-cycle pulse.

Top module: `lane_wv_cache`

## Requirements
- R1: After reset the cache holds no lines, `req_ready` is 1, and `rsp_valid`, `mem_req_valid` and `flush_done` are 0.
- R2: A store miss claims an entry without any memory read; only the bytes selected by `req_be` become valid (bit k of `req_be` is byte k of the 32-bit word, which sits at line byte 4*`req_addr[5:2]`+k).
- R3: Stores never cause a memory write by themselves; memory is written only when a line is evicted or flushed.
- R4: A load whose requested bytes are all valid raises `rsp_valid` with the word in the cycle after acceptance, with no memory request.
- R5: A load of a present or absent line that lacks any requested byte issues exactly one line read; the returned line fills only the bytes not already valid, then every byte of the line is valid.
- R6: Evicting an entry with dirty bytes issues one write to its line address (`req_addr[31:6]`) with `mem_req_wmask` bit i set exactly for dirty byte i, before any read for the new line.
- R7: Evicting an entry with no dirty bytes issues no memory write.
- R8: The victim is the lowest-numbered empty entry. When none is empty, it is chosen round-robin: a pointer starting at entry 0 moves to the next entry each time the entry it names is filled (tree pseudo-LRU when `REPL` selects it).
- R9: A flush writes back each entry holding dirty bytes, one per memory handshake, then empties every entry and raises `flush_done` for exactly one cycle.
- R10: `req_ready` is 0 while a miss, writeback or flush is in progress, and no lane request is accepted while a memory request is pending.
- R11: A memory request that is not accepted keeps its valid, address and direction until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lane request present |
| req_ready | output | 1 | Cache can accept a lane request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the word |
| req_be | input | WORD_BYTES | Byte enables within the word |
| req_wdata | input | WORD_BYTES*8 | Store data |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_rdata | output | WORD_BYTES*8 | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = masked line write, 0 = line read |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| mem_req_wmask | output | LINE_BYTES | Per-byte write mask |
| mem_req_wdata | output | LINE_BYTES*8 | Line write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | LINE_BYTES*8 | Returned line |
| flush_start | input | 1 | Start a flush (pulse) |
| flush_done | output | 1 | Flush complete (one cycle) |

## Verification
The hardest case to reach from the ports is a dirty eviction under round-robin order. That needs a full cache, a known pointer position and a dirty byte in exactly the entry the pointer names. The stimulus first flushes to empty the cache. It then fills all sixteen entries with loads of distinct lines, so the fill order and the pointer are known. It dirties one byte of the oldest line and then misses on a new line. The write mask, the written byte in the memory model, and the hit or miss behaviour of the next lines show which entry was chosen.

// File: rtl/lwv_pkg.sv
package lwv_pkg;

    localparam int REPL_RR   = 0;
    localparam int REPL_PLRU = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_FL_SCAN,
        ST_FL_WB,
        ST_FL_END
    } cstate_e;

endpackage

// File: rtl/lwv_lookup.sv
module lwv_lookup #(
    parameter int LINES = 16,
    parameter int TAG_W = 26,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0]            ent_vld,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lwv_victim.sv
module lwv_victim #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES),
    parameter int REPL  = lwv_pkg::REPL_RR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] ent_vld,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_alloc,
    output logic [IDX_W-1:0] victim
);
    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] pol_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    if (REPL == lwv_pkg::REPL_PLRU) begin : g_plru
        logic [LINES-1:0] tree_q, tree_d;
        logic             unused_alloc;
        assign unused_alloc = touch_alloc;

        always_comb begin
            int n;
            n = 1;
            for (int l = 0; l < IDX_W; l++) n = n * 2 + int'(tree_q[n]);
            pol_idx = IDX_W'(n - LINES);
        end

        always_comb begin
            int n;
            tree_d = tree_q;
            n = 1;
            for (int l = 0; l < IDX_W; l++) begin
                tree_d[n] = !touch_idx[IDX_W-1-l];
                n = n * 2 + int'(touch_idx[IDX_W-1-l]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst)              tree_q <= '0;
            else if (touch_valid) tree_q <= tree_d;
        end
    end else begin : g_rr
        logic [IDX_W-1:0] ptr_q;
        assign pol_idx = ptr_q;

        always_ff @(posedge clk) begin
            if (rst) ptr_q <= '0;
            else if (touch_valid && touch_alloc && touch_idx == ptr_q)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    assign victim = have_free ? free_idx : pol_idx;
endmodule

// File: rtl/lane_wv_cache.sv
module lane_wv_cache
    import lwv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 4,
    parameter int REPL       = REPL_RR,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int WORD_W = WORD_BYTES * 8,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_BYTES-1:0] req_be,
    input  logic [WORD_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [WORD_W-1:0]     rsp_rdata,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [TAG_W-1:0]      mem_req_addr,
    output logic [LINE_BYTES-1:0] mem_req_wmask,
    output logic [LINE_W-1:0]     mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic [LINE_W-1:0]     mem_rsp_data,
    input  logic                  flush_start,
    output logic                  flush_done
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int BOFF_W = $clog2(WORD_BYTES);
    localparam int WSEL_W = OFF_W - BOFF_W;

    cstate_e state_q;

    logic [LINES-1:0]            ent_vld_q;
    logic [LINES-1:0][TAG_W-1:0] tag_q;
    logic [LINE_W-1:0]           data_q   [LINES];
    logic [LINE_BYTES-1:0]       bval_q   [LINES];
    logic [LINE_BYTES-1:0]       bdirty_q [LINES];

    logic                  p_write, p_new;
    logic [TAG_W-1:0]      p_tag;
    logic [WSEL_W-1:0]     p_wsel;
    logic [LINE_BYTES-1:0] p_lmask;
    logic [LINE_W-1:0]     p_ldata;
    logic [IDX_W-1:0]      p_idx, fl_idx;
    logic                  flush_pend_q, rsp_valid_q;
    logic [WORD_W-1:0]     rsp_data_q;

    logic [TAG_W-1:0]      req_tag;
    logic [WSEL_W-1:0]     req_wsel;
    logic [LINE_BYTES-1:0] req_lmask;
    logic [LINE_W-1:0]     req_ldata, req_bits, p_bits, keep_bits, fill_line;
    logic                  lk_hit, all_valid, vic_dirty, accept, unused_boff;
    logic [IDX_W-1:0]      lk_idx, vic_idx, sel_idx, use_idx, alloc_idx;
    logic                  st_hit, ld_hit, st_now, evict_done, fill_done, use_valid, alloc_valid;

    assign req_tag     = req_addr[ADDR_W-1:OFF_W];
    assign req_wsel    = req_addr[OFF_W-1:BOFF_W];
    assign unused_boff = ^req_addr[BOFF_W-1:0];
    assign req_lmask   = LINE_BYTES'(req_be) << (req_wsel * WORD_BYTES);
    assign req_ldata   = LINE_W'(req_wdata) << (req_wsel * WORD_W);

    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            req_bits[b*8 +: 8]  = {8{req_lmask[b]}};
            p_bits[b*8 +: 8]    = {8{p_lmask[b]}};
            keep_bits[b*8 +: 8] = {8{!p_new && bval_q[p_idx][b]}};
        end
    end
    assign fill_line = (data_q[p_idx] & keep_bits) | (mem_rsp_data & ~keep_bits);

    lwv_lookup #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
        .ent_vld(ent_vld_q), .tags(tag_q), .key(req_tag),
        .hit(lk_hit), .hit_idx(lk_idx)
    );

    assign accept     = req_valid && req_ready;
    assign all_valid  = (req_lmask & ~bval_q[lk_idx]) == '0;
    assign vic_dirty  = ent_vld_q[vic_idx] && (|bdirty_q[vic_idx]);
    assign st_hit     = accept && req_write && lk_hit;
    assign ld_hit     = accept && !req_write && lk_hit && all_valid;
    assign st_now     = accept && req_write && !lk_hit && !vic_dirty;
    assign evict_done = (state_q == ST_EVICT) && mem_req_ready;
    assign fill_done  = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
    assign use_valid  = st_hit || ld_hit || st_now || (evict_done && p_write) || fill_done;
    assign use_idx    = (st_hit || ld_hit) ? lk_idx : (st_now ? vic_idx : p_idx);
    assign alloc_valid = st_now || (evict_done && p_write) || (fill_done && p_new);
    assign alloc_idx  = st_now ? vic_idx : p_idx;

    lwv_victim #(.LINES(LINES), .IDX_W(IDX_W), .REPL(REPL)) u_victim (
        .clk(clk), .rst(rst), .ent_vld(ent_vld_q),
        .touch_valid(use_valid), .touch_idx(use_idx), .touch_alloc(alloc_valid),
        .victim(vic_idx)
    );

    assign req_ready     = (state_q == ST_IDLE) && !flush_pend_q;
    assign sel_idx       = (state_q == ST_FL_WB) ? fl_idx : p_idx;
    assign mem_req_valid = state_q inside {ST_EVICT, ST_FILL_REQ, ST_FL_WB};
    assign mem_req_write = (state_q != ST_FILL_REQ);
    assign mem_req_addr  = (state_q == ST_FILL_REQ) ? p_tag : tag_q[sel_idx];
    assign mem_req_wmask = mem_req_write ? bdirty_q[sel_idx] : '0;
    assign mem_req_wdata = data_q[sel_idx];
    assign flush_done    = (state_q == ST_FL_END);
    assign rsp_valid     = rsp_valid_q;
    assign rsp_rdata     = rsp_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            ent_vld_q    <= '0;
            flush_pend_q <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_data_q   <= '0;
            fl_idx       <= '0;
            p_idx        <= '0;
            p_new        <= 1'b0;
            for (int i = 0; i < LINES; i++) begin
                bval_q[i]   <= '0;
                bdirty_q[i] <= '0;
            end
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (flush_pend_q) begin
                        flush_pend_q <= 1'b0;
                        fl_idx       <= '0;
                        state_q      <= ST_FL_SCAN;
                    end else if (accept) begin
                        p_write <= req_write;
                        p_tag   <= req_tag;
                        p_wsel  <= req_wsel;
                        p_lmask <= req_lmask;
                        p_ldata <= req_ldata;
                        if (req_write && lk_hit) begin
                            data_q[lk_idx]   <= (data_q[lk_idx] & ~req_bits) | (req_ldata & req_bits);
                            bval_q[lk_idx]   <= bval_q[lk_idx] | req_lmask;
                            bdirty_q[lk_idx] <= bdirty_q[lk_idx] | req_lmask;
                        end else if (req_write && !vic_dirty) begin
                            ent_vld_q[vic_idx] <= 1'b1;
                            tag_q[vic_idx]     <= req_tag;
                            data_q[vic_idx]    <= (data_q[vic_idx] & ~req_bits) | (req_ldata & req_bits);
                            bval_q[vic_idx]    <= req_lmask;
                            bdirty_q[vic_idx]  <= req_lmask;
                        end else if (req_write) begin
                            p_idx   <= vic_idx;
                            state_q <= ST_EVICT;
                        end else if (lk_hit && all_valid) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= WORD_W'(data_q[lk_idx] >> (req_wsel * WORD_W));
                        end else if (lk_hit) begin
                            p_idx   <= lk_idx;
                            p_new   <= 1'b0;
                            state_q <= ST_FILL_REQ;
                        end else begin
                            p_idx   <= vic_idx;
                            p_new   <= 1'b1;
                            state_q <= vic_dirty ? ST_EVICT : ST_FILL_REQ;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_req_ready) begin
                        if (p_write) begin
                            tag_q[p_idx]    <= p_tag;
                            data_q[p_idx]   <= (data_q[p_idx] & ~p_bits) | (p_ldata & p_bits);
                            bval_q[p_idx]   <= p_lmask;
                            bdirty_q[p_idx] <= p_lmask;
                            state_q         <= ST_IDLE;
                        end else begin
                            ent_vld_q[p_idx] <= 1'b0;
                            bval_q[p_idx]    <= '0;
                            bdirty_q[p_idx]  <= '0;
                            state_q          <= ST_FILL_REQ;
                        end
                    end
                end
                ST_FILL_REQ: if (mem_req_ready) state_q <= ST_FILL_WAIT;
                ST_FILL_WAIT: begin
                    if (mem_rsp_valid) begin
                        data_q[p_idx]    <= fill_line;
                        bval_q[p_idx]    <= '1;
                        if (p_new) bdirty_q[p_idx] <= '0;
                        tag_q[p_idx]     <= p_tag;
                        ent_vld_q[p_idx] <= 1'b1;
                        rsp_valid_q      <= 1'b1;
                        rsp_data_q       <= WORD_W'(fill_line >> (p_wsel * WORD_W));
                        state_q          <= ST_IDLE;
                    end
                end
                ST_FL_SCAN: begin
                    if (ent_vld_q[fl_idx] && (|bdirty_q[fl_idx])) state_q <= ST_FL_WB;
                    else if (fl_idx == IDX_W'(LINES - 1))          state_q <= ST_FL_END;
                    else                                            fl_idx  <= fl_idx + 1'b1;
                end
                ST_FL_WB: begin
                    if (mem_req_ready) begin
                        bdirty_q[fl_idx] <= '0;
                        if (fl_idx == IDX_W'(LINES - 1)) state_q <= ST_FL_END;
                        else begin
                            fl_idx  <= fl_idx + 1'b1;
                            state_q <= ST_FL_SCAN;
                        end
                    end
                end
                ST_FL_END: begin
                    ent_vld_q <= '0;
                    for (int i = 0; i < LINES; i++) begin
                        bval_q[i]   <= '0;
                        bdirty_q[i] <= '0;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (flush_start) flush_pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lwv_checker.sv
module lwv_checker #(
    parameter int TAG_W      = 26,
    parameter int LINE_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_write,
    input logic                  rsp_valid,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_req_write,
    input logic [TAG_W-1:0]      mem_req_addr,
    input logic [LINE_BYTES-1:0] mem_req_wmask,
    input logic                  mem_rsp_valid,
    input logic                  flush_done
);
    // R4
    rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready && !req_write) || $past(mem_rsp_valid)));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done);

    // R10
    single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    // R7
    no_empty_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wmask != '0));
endmodule

bind lane_wv_cache lwv_checker #(.TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wmask(mem_req_wmask),
    .mem_rsp_valid(mem_rsp_valid), .flush_done(flush_done)
);

// File: tb/lane_wv_cache_test.sv
module lane_wv_cache_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1'b1;
    logic [25:0] mem_req_addr;
    logic [63:0] mem_req_wmask;
    logic [511:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [511:0] mem_rsp_data = '0;
    logic flush_start = 1'b0;
    logic flush_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_wv_cache uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wmask(mem_req_wmask), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .flush_start(flush_start), .flush_done(flush_done)
    );

    // memory model: 64 lines, read data returns a few cycles after the request
    logic [7:0]  mem_b [64][64];
    logic [7:0]  gold  [64][64];
    int          rd_count = 0, wr_count = 0, rd_cnt = 0;
    logic [5:0]  rd_tag;
    logic [25:0] last_waddr;
    logic [63:0] last_wmask;
    int n_chk = 0, n_fail = 0;

    function automatic logic [7:0] pattern(int t, int b);
        return 8'((t * 7 + b * 3 + 1) & 8'hff);
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst) begin
            for (int t = 0; t < 64; t++)
                for (int b = 0; b < 64; b++) mem_b[t][b] <= pattern(t, b);
            rd_cnt <= 0;
        end else begin
            if (rd_cnt > 0) begin
                rd_cnt <= rd_cnt - 1;
                if (rd_cnt == 1) begin
                    mem_rsp_valid <= 1'b1;
                    for (int b = 0; b < 64; b++) mem_rsp_data[b*8 +: 8] <= mem_b[rd_tag][b];
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    for (int b = 0; b < 64; b++)
                        if (mem_req_wmask[b]) mem_b[mem_req_addr[5:0]][b] <= mem_req_wdata[b*8 +: 8];
                    wr_count   <= wr_count + 1;
                    last_waddr <= mem_req_addr;
                    last_wmask <= mem_req_wmask;
                end else begin
                    rd_count <= rd_count + 1;
                    rd_tag   <= mem_req_addr[5:0];
                    rd_cnt   <= 3;
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(int t, int w);
        return {26'(t), 4'(w), 2'b00};
    endfunction

    function automatic logic [31:0] gold_word(int t, int w);
        return {gold[t][w*4+3], gold[t][w*4+2], gold[t][w*4+1], gold[t][w*4]};
    endfunction

    // one lane operation; lat = negedges after acceptance until response, stall = ready low right after acceptance
    task automatic lane_op(input logic w, input int t, input int wd, input logic [3:0] be,
                           input logic [31:0] d, output logic [31:0] q, output int lat, output logic stall);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = addr_of(t, wd); req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        stall = !req_ready;
        lat = 1;
        q = '0;
        if (w) begin
            for (int k = 0; k < 4; k++) if (be[k]) gold[t][wd*4+k] = d[k*8 +: 8];
        end else begin
            while (!rsp_valid && lat < 100) begin
                @(negedge clk);
                lat++;
            end
            q = rsp_rdata;
        end
    endtask

    task automatic t_reset;
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        check("R1 flush_done", 64'(flush_done), 64'd0);
    endtask

    task automatic t_store_alloc;
        logic [31:0] q; int lat; logic st; int r0, w0;
        r0 = rd_count; w0 = wr_count;
        lane_op(1'b1, 1, 0, 4'hf, 32'hA1B2C3D4, q, lat, st);
        check("R2 no read on store miss", 64'(rd_count - r0), 64'd0);
        check("R3 no write on store", 64'(wr_count - w0), 64'd0);
        lane_op(1'b0, 1, 0, 4'hf, 32'h0, q, lat, st);
        check("R4 hit latency", 64'(lat), 64'd1);
        check("R4 hit data", 64'(q), 64'(gold_word(1, 0)));
        check("R4 no memory on hit", 64'(rd_count - r0), 64'd0);
    endtask

    task automatic t_partial_fill;
        logic [31:0] q; int lat; logic st; int r0;
        r0 = rd_count;
        lane_op(1'b1, 2, 3, 4'b0010, 32'h0000BB00, q, lat, st);
        check("R2 partial store no read", 64'(rd_count - r0), 64'd0);
        lane_op(1'b0, 2, 3, 4'hf, 32'h0, q, lat, st);
        check("R10 stalled during fill", 64'(st), 64'd1);
        check("R5 one line read", 64'(rd_count - r0), 64'd1);
        check("R5 merged word", 64'(q), 64'(gold_word(2, 3)));
        lane_op(1'b0, 2, 9, 4'hf, 32'h0, q, lat, st);
        check("R5 line fully valid after fill", 64'(rd_count - r0), 64'd1);
        check("R5 other word data", 64'(q), 64'(gold_word(2, 9)));
    endtask

    task automatic do_flush(output int cycles, output logic pulse_ok);
        @(negedge clk); flush_start = 1'b1;
        @(negedge clk); flush_start = 1'b0;
        check("R10 ready low on flush", 64'(req_ready), 64'd0);
        cycles = 0;
        while (!flush_done && cycles < 500) begin
            @(negedge clk);
            cycles++;
        end
        pulse_ok = flush_done;
        @(negedge clk);
        pulse_ok = pulse_ok && !flush_done;
    endtask

    task automatic t_evict;
        logic [31:0] q; int lat; logic st; int r0, w0, cyc; logic ok;
        do_flush(cyc, ok);
        for (int t = 10; t < 26; t++) begin
            lane_op(1'b0, t, 0, 4'hf, 32'h0, q, lat, st);
            if (q !== gold_word(t, 0)) check("R5 fill data", 64'(q), 64'(gold_word(t, 0)));
        end
        w0 = wr_count;
        lane_op(1'b1, 10, 1, 4'b0100, 32'h00CC0000, q, lat, st);
        check("R3 store hit no write", 64'(wr_count - w0), 64'd0);
        r0 = rd_count;
        lane_op(1'b0, 26, 0, 4'hf, 32'h0, q, lat, st);
        check("R6 one writeback", 64'(wr_count - w0), 64'd1);
        check("R6 writeback address", 64'(last_waddr), 64'd10);
        check("R6 writeback mask", last_wmask, 64'h40);
        check("R6 written byte", 64'(mem_b[10][6]), 64'hCC);
        check("R8 new line data", 64'(q), 64'(gold_word(26, 0)));
        r0 = rd_count;
        lane_op(1'b0, 12, 0, 4'hf, 32'h0, q, lat, st);
        check("R8 unrelated line kept", 64'(rd_count - r0), 64'd0);
        w0 = wr_count;
        lane_op(1'b0, 27, 0, 4'hf, 32'h0, q, lat, st);
        check("R7 clean victim dropped", 64'(wr_count - w0), 64'd0);
        r0 = rd_count;
        lane_op(1'b0, 11, 0, 4'hf, 32'h0, q, lat, st);
        check("R8 round-robin evicted entry 1", 64'(rd_count - r0), 64'd1);
        lane_op(1'b0, 10, 1, 4'hf, 32'h0, q, lat, st);
        check("R3 data back from memory", 64'(q), 64'(gold_word(10, 1)));
    endtask

    task automatic t_flush;
        logic [31:0] q; int lat; logic st; int r0, w0, cyc; logic ok;
        lane_op(1'b1, 15, 2, 4'b0001, 32'h0000005A, q, lat, st);
        lane_op(1'b1, 16, 7, 4'b1000, 32'h77000000, q, lat, st);
        w0 = wr_count;
        do_flush(cyc, ok);
        check("R9 done single pulse", 64'(ok), 64'd1);
        check("R9 writebacks", 64'(wr_count - w0), 64'd2);
        check("R9 memory line 15", 64'(mem_b[15][8]), 64'h5A);
        check("R9 memory line 16", 64'(mem_b[16][31]), 64'h77);
        r0 = rd_count;
        lane_op(1'b0, 15, 2, 4'hf, 32'h0, q, lat, st);
        check("R9 invalidated", 64'(rd_count - r0), 64'd1);
        check("R9 data after flush", 64'(q), 64'(gold_word(15, 2)));
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int t = 0; t < 64; t++)
            for (int b = 0; b < 64; b++) gold[t][b] = pattern(t, b);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_store_alloc();
        t_partial_fill();
        t_evict();
        t_flush();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end
endmodule